// File: doc/BRIEF.md
# Post-Trigger Cell Readout Sequencer with Supply Settle Wait

This block controls the readout of a switched-capacitor sampling array once a trigger arrives. While idle it keeps the sampling wave running. A trigger stops the wave, passes through a one-cycle start-readout step, and then holds for a programmable number of clock cycles. Starting and stopping the wave pulls the supply down, and the array's output level follows the supply. The hold lets the supply recover before any conversion, at the cost of dead time. A setting of zero removes the hold completely, for systems that correct the baseline afterwards.

After the hold, the sequencer walks the cell address upward from zero through every cell of the array. It pulses the ADC start once per cell, takes the converted value a fixed latency later, and forwards it with its address and a usable flag. The cells at both ends of the array give unreliable samples. The outermost cell on each side is always flagged unusable, and a wide option flags the two outermost cells on each side. When the last cell has been forwarded, a done flag stays high until it is acknowledged. The sequencer then restarts the wave and returns to idle.

The settle length is a 20-bit cycle count written by software. About 120 us (30000 cycles at 250 MHz) is the usual setting.

Top module: `cell_readout_seq`

## Requirements
- R1: A trigger sampled high while idle makes `wave_en` low and `busy` high on the next clock edge.
- R2: With a settle length N > 0, the first `adc_start` pulse is high in the cycle that follows the (N+2)th clock edge after the edge that took the trigger. N is captured when the hold begins, so later changes to `settle_cycles` do not alter that sequence.
- R3: A settle length of 0 skips the hold, and the first `adc_start` follows the 2nd edge after the trigger edge.
- R4: Readout addresses cells 0 to CELLS-1 in ascending order. Each cell gets exactly one one-cycle `adc_start`, and consecutive starts are ADC_LAT+1 cycles apart.
- R5: Each cell yields one `smp_strobe` cycle. In that cycle `smp_addr` holds the cell address and `smp_data` holds `adc_data` as it stood ADC_LAT cycles after that cell's start, so the default gives 1024 strobes.
- R6: With `edge_wide`=0, cells 0 and CELLS-1 carry `smp_usable`=0 and all other cells carry 1, which gives 1022 usable cells by default.
- R7: With `edge_wide`=1 (sampled at the trigger), cells 0, 1, CELLS-2 and CELLS-1 carry `smp_usable`=0, which gives 1020 usable cells by default.
- R8: `done` rises in the cycle of the last strobe and stays high until `ack`. The edge that samples `ack` returns the block to idle, with `wave_en`=1, `busy`=0 and `done`=0.
- R9: A trigger that arrives while `busy` is high has no effect. It starts no new sequence and does not disturb the running readout or the done state.
- R10: During and directly after reset, `wave_en`=1, `busy`=0, `done`=0, `adc_start`=0 and `smp_strobe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Trigger request, acted on only while idle |
| settle_cycles | input | 20 | Supply settle hold in clock cycles, 0 skips it |
| edge_wide | input | 1 | 1 masks two cells at each end instead of one |
| ack | input | 1 | Acknowledges `done` and restarts the wave |
| wave_en | output | 1 | Sampling wave enable, high while idle |
| busy | output | 1 | High from wave stop until acknowledge |
| adc_start | output | 1 | One-cycle conversion start per cell |
| adc_data | input | 12 | Converted sample from the ADC |
| cell_addr | output | 10 | Cell currently being converted |
| smp_strobe | output | 1 | One-cycle marker of a forwarded sample |
| smp_data | output | 12 | Forwarded sample value |
| smp_addr | output | 10 | Cell address of the forwarded sample |
| smp_usable | output | 1 | 0 for masked edge cells |
| done | output | 1 | Readout complete, held until `ack` |

## Verification
A wrong state in the control sequence shows up first in the timing of the first `adc_start` against the trigger. An off-by-one in the hold counter, or a hold that is not skipped when it should be, moves that pulse by whole cycles, and it shows within a few hundred cycles of the trigger. Faults in the address stepper or the sample register show in the very first few strobes, as a wrong address, a wrong value, a wrong usable flag or a wrong start spacing. Faults in the edge mask appear at cells 0, 1 and the top two cells, and as a wrong usable count once `done` rises. A wrong return path shows right after `ack` or after a trigger during readout, as a `busy` or `wave_en` that does not match idle.

// File: rtl/cell_readout_pkg.sv
package cell_readout_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STOP,
      ST_START,
      ST_WAIT,
      ST_READ,
      ST_DONE
   } seq_state_t;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int WAIT_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] len,
   output logic [WAIT_W-1:0] left,
   output logic              last
);

   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= len;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign left = cnt_q;
   assign last = (cnt_q == WAIT_W'(1));

   // R2
   tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/cell_stepper.sv
module cell_stepper #(
   parameter int CELLS     = 1024,
   parameter int DATA_W    = 12,
   parameter int ADC_LAT   = 1,
   parameter bit WIDE_OPT  = 1'b1,
   localparam int ADDR_W   = $clog2(CELLS),
   localparam int PH_W     = $clog2(ADC_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wide,
   input  logic [DATA_W-1:0] adc_data,
   output logic              adc_start,
   output logic [ADDR_W-1:0] cell_addr,
   output logic              last_cap,
   output logic              smp_strobe,
   output logic [DATA_W-1:0] smp_data,
   output logic [ADDR_W-1:0] smp_addr,
   output logic              smp_usable
);

   localparam logic [ADDR_W-1:0] TOP_CELL = ADDR_W'(CELLS - 1);

   logic [ADDR_W-1:0] addr_q;
   logic [PH_W-1:0]   ph_q;
   logic              capture;
   logic              usable_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         ph_q   <= '0;
      end else if (!run) begin
         addr_q <= '0;
         ph_q   <= '0;
      end else if (ph_q == PH_W'(ADC_LAT)) begin
         ph_q   <= '0;
         addr_q <= addr_q + 1'b1;
      end else begin
         ph_q   <= ph_q + 1'b1;
      end
   end

   assign adc_start = run && (ph_q == '0);
   assign capture   = run && (ph_q == PH_W'(ADC_LAT));
   assign last_cap  = capture && (addr_q == TOP_CELL);
   assign cell_addr = addr_q;

   generate
      if (WIDE_OPT) begin : g_mask_sel
         always_comb begin
            if (wide)
               usable_now = (addr_q >= ADDR_W'(2)) && (addr_q <= ADDR_W'(CELLS - 3));
            else
               usable_now = (addr_q >= ADDR_W'(1)) && (addr_q <= ADDR_W'(CELLS - 2));
         end
      end else begin : g_mask_fixed
         always_comb
            usable_now = (addr_q >= ADDR_W'(1)) && (addr_q <= ADDR_W'(CELLS - 2));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_strobe <= 1'b0;
         smp_data   <= '0;
         smp_addr   <= '0;
         smp_usable <= 1'b0;
      end else begin
         smp_strobe <= capture;
         if (capture) begin
            smp_data   <= adc_data;
            smp_addr   <= addr_q;
            smp_usable <= usable_now;
         end
      end
   end

   // R4
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);

   // R6
   edge_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_strobe && (smp_addr == '0 || smp_addr == TOP_CELL)) |-> !smp_usable);

endmodule

// File: rtl/cell_readout_seq.sv
module cell_readout_seq
   import cell_readout_pkg::*;
#(
   parameter int CELLS    = 1024,
   parameter int DATA_W   = 12,
   parameter int WAIT_W   = 20,
   parameter int ADC_LAT  = 1,
   parameter bit WIDE_OPT = 1'b1,
   localparam int ADDR_W  = $clog2(CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [WAIT_W-1:0] settle_cycles,
   input  logic              edge_wide,
   input  logic              ack,
   output logic              wave_en,
   output logic              busy,
   output logic              adc_start,
   input  logic [DATA_W-1:0] adc_data,
   output logic [ADDR_W-1:0] cell_addr,
   output logic              smp_strobe,
   output logic [DATA_W-1:0] smp_data,
   output logic [ADDR_W-1:0] smp_addr,
   output logic              smp_usable,
   output logic              done
);

   generate
      if (CELLS < 8) begin : g_bad_cells
         $error("CELLS must be at least 8");
      end
      if (ADC_LAT < 1) begin : g_bad_lat
         $error("ADC_LAT must be at least 1");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("WAIT_W must be at least 1");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic              tmr_load;
   logic              tmr_last;
   logic [WAIT_W-1:0] tmr_left;
   logic              last_cap;
   logic              wide_q;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      unique case (state_q)
         ST_IDLE:  if (trig) state_d = ST_STOP;
         ST_STOP:  state_d = ST_START;
         ST_START: begin
            if (settle_cycles == '0) begin
               state_d = ST_READ;
            end else begin
               tmr_load = 1'b1;
               state_d  = ST_WAIT;
            end
         end
         ST_WAIT:  if (tmr_last) state_d = ST_READ;
         ST_READ:  if (last_cap) state_d = ST_DONE;
         ST_DONE:  if (ack) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   generate
      if (WIDE_OPT) begin : g_wide_latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wide_q <= 1'b0;
            else if (state_q == ST_IDLE && trig)
               wide_q <= edge_wide;
         end
      end else begin : g_wide_off
         assign wide_q = 1'b0;
      end
   endgenerate

   settle_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .len   (settle_cycles),
      .left  (tmr_left),
      .last  (tmr_last)
   );

   cell_stepper #(
      .CELLS    (CELLS),
      .DATA_W   (DATA_W),
      .ADC_LAT  (ADC_LAT),
      .WIDE_OPT (WIDE_OPT)
   ) u_stepper (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (state_q == ST_READ),
      .wide       (wide_q),
      .adc_data   (adc_data),
      .adc_start  (adc_start),
      .cell_addr  (cell_addr),
      .last_cap   (last_cap),
      .smp_strobe (smp_strobe),
      .smp_data   (smp_data),
      .smp_addr   (smp_addr),
      .smp_usable (smp_usable)
   );

   assign wave_en = (state_q == ST_IDLE);
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_DONE);

   // R1
   trig_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig) |=> (busy && !wave_en));

   // R2
   settle_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> (tmr_left != '0));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ack) |=> done);

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R4
   start_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> (busy && !wave_en && !done));

endmodule

// File: tb/cell_readout_seq_bench.sv
module cell_readout_seq_bench;

   localparam int CELLS   = 1024;
   localparam int DATA_W  = 12;
   localparam int WAIT_W  = 20;
   localparam int ADC_LAT = 1;
   localparam int ADDR_W  = $clog2(CELLS);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig = 1'b0;
   logic [WAIT_W-1:0] settle_cycles = '0;
   logic              edge_wide = 1'b0;
   logic              ack = 1'b0;
   logic              wave_en, busy, adc_start, smp_strobe, smp_usable, done;
   logic [DATA_W-1:0] adc_data, smp_data;
   logic [ADDR_W-1:0] cell_addr, smp_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign adc_data = DATA_W'(cell_addr * 7 + 3);

   cell_readout_seq #(
      .CELLS(CELLS), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .ADC_LAT(ADC_LAT)
   ) u_cell_readout_seq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .settle_cycles(settle_cycles),
      .edge_wide(edge_wide), .ack(ack), .wave_en(wave_en), .busy(busy),
      .adc_start(adc_start), .adc_data(adc_data), .cell_addr(cell_addr),
      .smp_strobe(smp_strobe), .smp_data(smp_data), .smp_addr(smp_addr),
      .smp_usable(smp_usable), .done(done)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // {edge_wide, settle length, late settle value}
   localparam logic [40:0] VEC [5] = '{
      {1'b0, 20'd0,  20'd0},
      {1'b1, 20'd1,  20'd0},
      {1'b0, 20'd5,  20'd0},
      {1'b1, 20'd37, 20'd900},
      {1'b0, 20'd20, 20'd3}
   };

   task automatic run_seq(input int n, input bit wide, input int n_late, input bit trig_busy);
      int cyc = 0;
      int starts = 0, strobes = 0, usable = 0;
      int bad_addr = 0, bad_data = 0, bad_use = 0, bad_gap = 0;
      int last_start = -1, t = 0;
      int lo;
      settle_cycles = WAIT_W'(n);
      edge_wide = wide;
      @(negedge clk) trig = 1'b1;
      @(negedge clk) trig = 1'b0;
      check("R1 wave_en after trigger", int'(wave_en), 0);
      check("R1 busy after trigger", int'(busy), 1);
      while (!adc_start && cyc < n + 10) begin
         @(negedge clk);
         cyc++;
         if (cyc == 2 && n >= 2 && n_late != 0) settle_cycles = WAIT_W'(n_late);
      end
      if (n == 0) check("R3 zero settle start delay", cyc, 2);
      else        check("R2 settle start delay", cyc, n + 2);
      lo = wide ? 2 : 1;
      if (trig_busy) trig = 1'b1;
      forever begin
         if (adc_start) begin
            if (last_start >= 0 && t - last_start != ADC_LAT + 1) bad_gap++;
            if (int'(cell_addr) != starts) bad_addr++;
            last_start = t;
            starts++;
         end
         if (smp_strobe) begin
            if (int'(smp_addr) != strobes) bad_addr++;
            if (smp_data != DATA_W'(strobes * 7 + 3)) bad_data++;
            if (smp_usable != (strobes >= lo && strobes <= CELLS - 1 - lo)) bad_use++;
            if (smp_usable) usable++;
            strobes++;
         end
         if (done || t > CELLS * (ADC_LAT + 1) + 10) break;
         @(negedge clk);
         t++;
      end
      check("R4 start count", starts, CELLS);
      check("R4 start spacing errors", bad_gap, 0);
      check("R5 strobe count", strobes, CELLS);
      check("R5 address order errors", bad_addr, 0);
      check("R5 data errors", bad_data, 0);
      check(wide ? "R7 usable flag errors" : "R6 usable flag errors", bad_use, 0);
      check(wide ? "R7 usable count" : "R6 usable count", usable, wide ? CELLS - 4 : CELLS - 2);
      check("R8 done at last strobe", int'(done), 1);
      repeat (3) @(negedge clk);
      check("R8 done held", int'(done), 1);
      if (trig_busy) check("R9 busy held under trigger", int'(busy), 1);
      trig = 1'b0;
      ack = 1'b1;
      @(negedge clk) ack = 1'b0;
      check("R8 idle after ack wave_en", int'(wave_en), 1);
      check("R8 idle after ack busy", int'(busy), 0);
      check("R8 idle after ack done", int'(done), 0);
      @(negedge clk);
      check("R9 no restart after ack", int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset wave_en", int'(wave_en), 1);
      check("R10 reset busy", int'(busy), 0);
      check("R10 reset done", int'(done), 0);
      check("R10 reset adc_start", int'(adc_start), 0);
      check("R10 reset smp_strobe", int'(smp_strobe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after reset wave_en", int'(wave_en), 1);
      check("R10 after reset busy", int'(busy), 0);

      foreach (VEC[i]) begin
         run_seq(int'(VEC[i][39:20]), VEC[i][40], int'(VEC[i][19:0]), i == 2);
      end

      // R2: nominal settle of 30000 cycles (120 us at 250 MHz), wide mask
      run_seq(30000, 1'b1, 0, 1'b0);
      // R9: trigger held through the whole readout
      run_seq(3, 1'b0, 0, 1'b1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule